// File: doc/BRIEF.md
# Complementary Output Pair with Asymmetric Dead Time

This block sits between a timer's compare unit and the port pins. It takes one waveform bit and gives out a true output and a complementary output. In the complementary pair setting, each output turns on only after its own programmable dead time has passed. Each output turns off at once. The two outputs therefore never drive high together. In every other setting the block acts as a one-cycle synchronizer on the true output and holds the complementary output low.

The dead-time word is 8 bits wide. Bits 7:4 set the turn-on delay of the true output. Bits 3:0 set the turn-on delay of the complementary output. Both delays count in units of a divided timer clock, and a 2-bit select picks the divider. The block latches the delay and the divider at the waveform edge that starts a count. A separate output tells the port mux to take its value from this block, and it is active whenever the compare output mode is not zero.

All pins are plain control and status levels. No data is passed as a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `dtg_top`

## Requirements
- R1: While reset is held, out_p_o and out_n_o are 0.
- R2: pin_ovr_o is 1 exactly when com_mode_i is not 2'b00.
- R3: The pair setting is pwm_mode_i=1 with com_mode_i=2'b01. Outside the pair setting, out_p_o equals wave_i as sampled at the previous clock edge, and out_n_o is 0.
- R4: In the pair setting, out_p_o rises 1 + H*P clock edges after the edge that first samples wave_i high. H is dt_val_i[7:4] and P is the divide factor.
- R5: In the pair setting, out_n_o rises 1 + L*P clock edges after the edge that first samples wave_i low. L is dt_val_i[3:0].
- R6: In the pair setting, each output falls at the first edge that samples the opposite waveform level, with no dead time added.
- R7: dt_psel_i codes 0, 1, 2 and 3 select P = 1, 2, 4 and 8.
- R8: A dead-time field of 0 gives the base latency of one edge.
- R9: If the waveform returns before a pending count ends, the pending output never rises, and the next edge starts a fresh count. out_p_o and out_n_o are never 1 together.
- R10: Changes to dt_val_i or dt_psel_i during a pending count do not change that count. They apply from the next waveform edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wave_i | input | 1 | Waveform bit from the compare unit |
| pwm_mode_i | input | 1 | 1 = a PWM counting mode, 0 = normal mode |
| com_mode_i | input | 2 | Compare output mode; 2'b01 selects the complementary pair |
| dt_psel_i | input | 2 | Dead-time clock divide select |
| dt_val_i | input | 8 | Dead-time word: [7:4] true output, [3:0] complementary output |
| out_p_o | output | 1 | True output |
| out_n_o | output | 1 | Complementary output |
| pin_ovr_o | output | 1 | Port override enable |

## Verification
The bench builds the block with its default parameters: 4-bit dead-time fields and a 2-bit divide select. These values make every field value from 0 to 15 and every divide factor from 1 to 8 reachable. The longest delay is 121 edges. The bench measures both extremes, an uneven pairing of high and low fields, a waveform that returns early, and settings that change while a count is pending.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [1:0] {
    COM_OFF  = 2'b00,
    COM_PAIR = 2'b01,
    COM_CLR  = 2'b10,
    COM_SET  = 2'b11
  } com_mode_e;

  function automatic logic pair_sel(input logic pwm, input logic [1:0] com);
    return pwm && (com == COM_PAIR);
  endfunction
endpackage

// File: rtl/dtg_prescaler.sv
module dtg_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [SEL_W-1:0] sel_q;
  logic [PC_W:0]   span;
  logic [PC_W-1:0] lim;

  always_comb begin
    span = (PC_W+1)'(1) << sel_q;
    lim  = PC_W'(span - (PC_W+1)'(1));
  end

  assign tick_o = run_i && (pc_q == lim);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pc_q  <= '0;
      sel_q <= '0;
    end else if (restart_i) begin
      pc_q  <= '0;
      sel_q <= sel_i;
    end else if (run_i) begin
      pc_q  <= (pc_q == lim) ? '0 : pc_q + PC_W'(1);
    end
  end
endmodule

// File: rtl/dtg_edge_delay.sv
module dtg_edge_delay #(
  parameter int DT_W  = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             tgt_i,
  input  logic [DT_W-1:0]  dt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             out_o
);
  logic            prev_q, busy_q, out_q;
  logic [DT_W-1:0] left_q;
  logic            rise, tick;

  assign rise  = en_i && tgt_i && !prev_q;
  assign out_o = out_q;

  dtg_prescaler #(.SEL_W(SEL_W)) psc_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .restart_i (rise),
    .run_i     (busy_q),
    .sel_i     (sel_i),
    .tick_o    (tick)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q <= 1'b0;
      busy_q <= 1'b0;
      out_q  <= 1'b0;
      left_q <= '0;
    end else begin
      prev_q <= tgt_i;
      if (!en_i || !tgt_i) begin
        out_q  <= 1'b0;
        busy_q <= 1'b0;
      end else if (rise) begin
        if (dt_i == '0) begin
          out_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          left_q <= dt_i;
        end
      end else if (busy_q && tick) begin
        if (left_q == DT_W'(1)) begin
          out_q  <= 1'b1;
          busy_q <= 1'b0;
        end else begin
          left_q <= left_q - DT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dtg_top.sv
module dtg_top #(
  parameter int DT_W  = 4,
  parameter int SEL_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wave_i,
  input  logic              pwm_mode_i,
  input  logic [1:0]        com_mode_i,
  input  logic [SEL_W-1:0]  dt_psel_i,
  input  logic [2*DT_W-1:0] dt_val_i,
  output logic              out_p_o,
  output logic              out_n_o,
  output logic              pin_ovr_o
);
  import dtg_pkg::*;

  localparam int NCH = 2;

  logic           sync_q;
  logic           pair_en;
  logic [NCH-1:0] ch_out;

  assign pair_en = pair_sel(pwm_mode_i, com_mode_i);

  always_ff @(posedge clk_i) begin
    if (rst_i) sync_q <= 1'b0;
    else       sync_q <= wave_i;
  end

  // channel 0: true output, upper field; channel 1: complement, lower field
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic            tgt;
    logic [DT_W-1:0] fld;
    assign tgt = (g == 0) ? wave_i : !wave_i;
    assign fld = dt_val_i[(NCH-1-g)*DT_W +: DT_W];
    dtg_edge_delay #(.DT_W(DT_W), .SEL_W(SEL_W)) dly_i (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .en_i  (pair_en),
      .tgt_i (tgt),
      .dt_i  (fld),
      .sel_i (dt_psel_i),
      .out_o (ch_out[g])
    );
  end

  assign out_p_o   = pair_en ? ch_out[0] : sync_q;
  assign out_n_o   = pair_en && ch_out[1];
  assign pin_ovr_o = (com_mode_i != COM_OFF);
endmodule

// File: rtl/dtg_chk.sv
module dtg_chk #(
  parameter int DT_W  = 4,
  parameter int SEL_W = 2
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              wave_i,
  input logic              pwm_mode_i,
  input logic [1:0]        com_mode_i,
  input logic [SEL_W-1:0]  dt_psel_i,
  input logic [2*DT_W-1:0] dt_val_i,
  input logic              out_p_o,
  input logic              out_n_o,
  input logic              pin_ovr_o
);
  logic pair;
  assign pair = pwm_mode_i && (com_mode_i == 2'b01);

  // R9
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(out_p_o && out_n_o));

  // R3
  sync_copy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && !pair && $past(!pair)) |-> (out_p_o == $past(wave_i)));

  // R3
  comp_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !pair |-> !out_n_o);

  // R6
  p_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && pair && $past(pair) && !$past(wave_i)) |-> !out_p_o);

  // R6
  n_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(!rst_i) && pair && $past(pair) && $past(wave_i)) |-> !out_n_o);

  // R1
  reset_low_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!out_p_o && !out_n_o));
endmodule

bind dtg_top dtg_chk #(.DT_W(DT_W), .SEL_W(SEL_W)) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .wave_i(wave_i), .pwm_mode_i(pwm_mode_i),
  .com_mode_i(com_mode_i), .dt_psel_i(dt_psel_i), .dt_val_i(dt_val_i),
  .out_p_o(out_p_o), .out_n_o(out_n_o), .pin_ovr_o(pin_ovr_o)
);

// File: tb/dtg_top_tb.sv
`timescale 1ns/1ps
module dtg_top_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wave;
  logic       pwm;
  logic [1:0] com;
  logic [1:0] psel;
  logic [7:0] dt;
  logic       op, on, ovr;
  int         errs = 0;
  int         checks = 0;
  int         overlaps = 0;

  always #2.5 clk = ~clk;

  dtg_top dut_i (
    .clk_i(clk), .rst_i(rst), .wave_i(wave), .pwm_mode_i(pwm),
    .com_mode_i(com), .dt_psel_i(psel), .dt_val_i(dt),
    .out_p_o(op), .out_n_o(on), .pin_ovr_o(ovr)
  );

  always @(negedge clk) if (!rst && op && on) overlaps++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // counts edges until the selected output is high; 999 on timeout
  task automatic measure(input bit sel_n, output int n);
    n = 999;
    for (int i = 1; i <= 300; i++) begin
      step();
      if ((sel_n ? on : op) == 1'b1) begin n = i; break; end
    end
  endtask

  task automatic t_reset();
    rst = 1; wave = 0; pwm = 1; com = 2'b01; psel = 0; dt = 8'h00;
    repeat (3) step();
    chk(op == 0 && on == 0, "R1 reset outputs", {op, on}, 0);
    rst = 0;
  endtask

  task automatic t_ovr();
    for (int c = 0; c < 4; c++) begin
      com = c[1:0]; #1;
      chk(ovr == (c != 0), "R2 override", ovr, c != 0);
    end
  endtask

  task automatic t_sync(input bit p, input logic [1:0] cm);
    bit pat [8] = '{1, 1, 0, 1, 0, 0, 1, 0};
    pwm = p; com = cm; dt = 8'hFF; psel = 2'd3;
    step();
    for (int i = 0; i < 8; i++) begin
      wave = pat[i];
      step();
      chk(op == pat[i] && on == 0, "R3 synchronizer copy", {op, on}, {pat[i], 1'b0});
    end
  endtask

  task automatic t_delay(input int h, input int l, input int s, input string req);
    int n, p;
    p = 1 << s;
    pwm = 1; com = 2'b01; psel = s[1:0]; dt = {h[3:0], l[3:0]};
    wave = 0;
    repeat (130) step();
    wave = 1;
    measure(0, n);
    chk(n == 1 + h * p, {req, " R4 true rise"}, n, 1 + h * p);
    repeat (3) step();
    wave = 0;
    step();
    chk(op == 0, {req, " R6 true fall"}, op, 0);
    if (l == 0) n = on ? 1 : 999;
    else measure(1, n);
    if (l != 0) n = n + 1;
    chk(n == 1 + l * p, {req, " R5 comp rise"}, n, 1 + l * p);
    wave = 1;
    step();
    chk(on == 0, {req, " R6 comp fall"}, on, 0);
  endtask

  task automatic t_glitch();
    int n;
    pwm = 1; com = 2'b01; psel = 0; dt = 8'h50;
    wave = 0; repeat (5) step();
    wave = 1; repeat (3) step();
    chk(op == 0, "R9 pending before retoggle", op, 0);
    wave = 0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk(op == 0, "R9 aborted output stays low", op, 0);
    end
    wave = 1;
    measure(0, n);
    chk(n == 6, "R9 fresh count", n, 6);
  endtask

  task automatic t_change();
    int n;
    pwm = 1; com = 2'b01; psel = 2'd1; dt = 8'h40;
    wave = 0; repeat (5) step();
    wave = 1;
    step(); step();
    dt = 8'hF0; psel = 2'd3;
    n = 999;
    for (int i = 3; i <= 300; i++) begin
      step();
      if (op) begin n = i; break; end
    end
    chk(n == 9, "R10 settings latched at edge", n, 9);
    wave = 0; repeat (3) step();
    wave = 1;
    measure(0, n);
    chk(n == 121, "R10 new settings on next edge", n, 121);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_ovr();
    t_sync(0, 2'b01);
    t_sync(1, 2'b11);
    t_sync(1, 2'b00);
    t_delay(0, 0, 0, "R8 zero fields");
    t_delay(3, 1, 0, "R7 divide 1");
    t_delay(2, 5, 1, "R7 divide 2");
    t_delay(1, 4, 2, "R7 divide 4");
    t_delay(15, 2, 3, "R7 divide 8");
    t_delay(7, 0, 2, "R8 zero low field");
    t_glitch();
    t_change();
    chk(overlaps == 0, "R9 never both high", overlaps, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule